// File: doc/BRIEF.md
# Four-Channel Keyboard-Controller-Style Mailbox Register Block

This block sits between a management controller and a host and carries four byte-wide mailbox channels in the keyboard-controller style. Each channel has three registers: a host-to-local data-in byte, a local-to-host data-out byte and a status byte. The status byte carries an input-full flag and an output-full flag. These flags are never written directly by the normal data path. They are set and cleared as side effects of accesses made from the two opposite sides.

The local side is a single-cycle 32-bit memory-mapped port over a 4 KB window, with byte-lane write strobes and registered read data. The host side is a small per-channel port that writes data-in and reads data-out or status. Control registers gate each channel. Channel 3 needs two separate enable bits. The control registers also arm a per-channel input-full interrupt. A second stage latches a vector of subdevice interrupt levels and reports their OR on one aggregated line.

Top module: `kcs_mbox_ctrl`

## Requirements
- R1: Implemented local registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x80, 0x84, 0x88, 0x8C and 0x100 (control, 32 bits each). The per-channel registers are: data-in at 0x24/0x28/0x2C/0x114, data-out at 0x30/0x34/0x38/0x118 and status at 0x3C/0x40/0x44/0x11C, for channels 1 to 4. Any other offset, including a word index of 72 or more, reads as zero and ignores writes. Data-in is read-only from the local side.
- R2: Local writes to control registers update only the byte lanes whose strobe is set. Data-out and status occupy bits 7:0 and are written only when the lane 0 strobe is set.
- R3: A host write to a channel's data register stores the byte in data-in and sets that channel's input-full flag (status bit 1).
- R4: A local read of data-in returns the stored byte and clears input-full. If a host data write hits the same channel in the same cycle, the host write wins: input-full stays set and the new byte is kept.
- R5: A local write to data-out stores the byte and sets output-full (status bit 0). A host read of the data register returns data-out and clears output-full.
- R6: A host write aimed at a status register changes nothing. A host status read returns the status byte. Bit 3, the command/data bit, is set or cleared only by a local status write.
- R7: Channel 1, 2 and 3 are enabled by bits 5, 6 and 7 of offset 0x00. Channel 3 also requires bit 2 of offset 0x10. Channel 4 is enabled by bit 0 of offset 0x100.
- R8: Input-full interrupt enables are bits 1, 2 and 3 of offset 0x08 for channels 1 to 3, and bit 1 of offset 0x100 for channel 4. A host data write raises the channel interrupt only when both that enable and the channel enable are set.
- R9: A local data-in read lowers the channel interrupt only if input-full was set at that moment; otherwise the interrupt keeps its level.
- R10: Each pending bit takes the level of its subdevice interrupt input one cycle later. The aggregated interrupt is high whenever any pending bit is set.
- R11: After reset every register, flag, interrupt and pending bit is zero, except offset 0x88, which holds the strap input value.
- R12: Local read data appears on the cycle after the read request and holds until the next local read. Host read data behaves the same way relative to host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cfg | input | 32 | Value loaded into offset 0x88 at reset |
| lcl_en | input | 1 | Local access request |
| lcl_we | input | 1 | Local access is a write |
| lcl_addr | input | 12 | Local byte address |
| lcl_be | input | 4 | Local byte-lane write strobes |
| lcl_wdata | input | 32 | Local write data |
| lcl_rdata | output | 32 | Local read data, registered |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_stat | input | 1 | Host access targets status (1) or data (0) |
| host_ch | input | 2 | Host channel index, 0 for channel 1 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| sub_irq_in | input | 5 | Subdevice interrupt levels |
| chan_irq | output | 4 | Per-channel input-full interrupts |
| agg_irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 72-word register array and five subdevice inputs. The four channel interrupts are looped back into the low subdevice lines and the fifth line is driven by the bench. The bench uses a nonzero strap value, so a reset value confused with zero shows up. With a 72-word array, word indices just past the channel 4 status are out of range, and so is a far word such as index 300. Random enable and strobe patterns then reach every gating combination, including channel 3 with only one of its two enables set.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;

  localparam int NUM_CH   = 4;
  localparam int NUM_CTL  = 10;
  localparam int ST_W     = 8;
  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_CD    = 3;
  localparam int SLOT_MAIN  = 0;
  localparam int SLOT_IE    = 2;
  localparam int SLOT_EXT   = 4;
  localparam int SLOT_STRAP = 7;
  localparam int SLOT_CH4   = 9;

  // word index of each control slot
  function automatic int ctl_word(input int slot);
    if (slot < 5)      return slot;
    else if (slot < 9) return 32 + slot - 5;
    else               return 64;
  endfunction

  function automatic int din_word(input int ch);
    return (ch < 3) ? 9 + ch : 69;
  endfunction

  function automatic int dout_word(input int ch);
    return (ch < 3) ? 12 + ch : 70;
  endfunction

  function automatic int stat_word(input int ch);
    return (ch < 3) ? 15 + ch : 71;
  endfunction

endpackage

// File: rtl/kcs_ctl_regs.sv
module kcs_ctl_regs
  import kcs_mbox_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int WORD_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     strap_val,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    word,
  input  logic [REG_W/8-1:0]   wr_be,
  input  logic [REG_W-1:0]     wr_data,
  output logic                 rd_hit,
  output logic [REG_W-1:0]     rd_val,
  output logic [NUM_CH-1:0]    ch_en,
  output logic [NUM_CH-1:0]    ibf_ie
);

  localparam int BE_W = REG_W / 8;

  logic [NUM_CTL-1:0][REG_W-1:0] ctl_flat;

  for (genvar s = 0; s < NUM_CTL; s++) begin : g_slot
    localparam bit IS_STRAP = (s == SLOT_STRAP);
    logic             ld;
    logic [REG_W-1:0] nxt;
    logic [REG_W-1:0] q;

    assign ld = wr_en && (int'(word) == ctl_word(s));

    always_comb begin
      nxt = q;
      for (int l = 0; l < BE_W; l++) begin
        if (wr_be[l]) nxt[l*8 +: 8] = wr_data[l*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= IS_STRAP ? strap_val : '0;
      else if (ld) q <= nxt;
    end

    assign ctl_flat[s] = q;
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int s = 0; s < NUM_CTL; s++) begin
      if (int'(word) == ctl_word(s)) begin
        rd_hit = 1'b1;
        rd_val = ctl_flat[s];
      end
    end
  end

  // channel 3 needs both the main bit and the extension bit
  assign ch_en  = {ctl_flat[SLOT_CH4][0],
                   ctl_flat[SLOT_MAIN][7] & ctl_flat[SLOT_EXT][2],
                   ctl_flat[SLOT_MAIN][6],
                   ctl_flat[SLOT_MAIN][5]};
  assign ibf_ie = {ctl_flat[SLOT_CH4][1],
                   ctl_flat[SLOT_IE][3],
                   ctl_flat[SLOT_IE][2],
                   ctl_flat[SLOT_IE][1]};

  // R7: enables move only on a local control write
  p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ch_en));

  // R8: interrupt enables move only on a local control write
  p_ie_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ibf_ie));

endmodule

// File: rtl/kcs_chan.sv
module kcs_chan
  import kcs_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_arm,
  input  logic              l_din_rd,
  input  logic              l_dout_wr,
  input  logic              l_st_wr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic [ST_W-1:0]   l_st_wdata,
  input  logic              h_din_wr,
  input  logic              h_dout_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] din_q,
  output logic [DATA_W-1:0] dout_q,
  output logic [ST_W-1:0]   st_q,
  output logic              irq_q
);

  logic [DATA_W-1:0] din_d, dout_d;
  logic [ST_W-1:0]   st_d;
  logic              irq_d;
  logic              st_ld;

  assign st_ld = l_st_wr | l_din_rd | l_dout_wr | h_dout_rd | h_din_wr;

  always_comb begin
    st_d = st_q;
    if (l_st_wr)   st_d = l_st_wdata;
    if (l_din_rd)  st_d[ST_IBF] = 1'b0;
    if (h_dout_rd) st_d[ST_OBF] = 1'b0;
    if (l_dout_wr) st_d[ST_OBF] = 1'b1;
    if (h_din_wr)  st_d[ST_IBF] = 1'b1;  // host wins over local drain
  end

  always_comb begin
    irq_d = irq_q;
    if (l_din_rd && st_q[ST_IBF]) irq_d = 1'b0;
    if (h_din_wr && irq_arm)      irq_d = 1'b1;
  end

  assign din_d  = h_wdata;
  assign dout_d = l_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      dout_q <= '0;
      st_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (h_din_wr)  din_q  <= din_d;
      if (l_dout_wr) dout_q <= dout_d;
      if (st_ld)     st_q   <= st_d;
      irq_q <= irq_d;
    end
  end

  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_din_wr |=> st_q[ST_IBF]);

  p_din_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_din_wr |=> din_q == $past(h_wdata));

  p_ibf_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l_din_rd && !h_din_wr && !l_st_wr |=> !st_q[ST_IBF]);

  p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    l_dout_wr |=> st_q[ST_OBF]);

  p_obf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    h_dout_rd && !l_dout_wr && !l_st_wr |=> !st_q[ST_OBF]);

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_din_wr && irq_arm |=> irq_q);

  p_irq_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_din_wr && !irq_arm && !l_din_rd |=> irq_q == $past(irq_q));

  p_irq_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !(l_din_rd && st_q[ST_IBF]) |=> irq_q);

  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_din_rd && st_q[ST_IBF] && !(h_din_wr && irq_arm) |=> !irq_q);

endmodule

// File: rtl/kcs_irq_agg.sv
module kcs_irq_agg #(
  parameter int NUM_SUB = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUB-1:0] sub_in,
  output logic               agg_irq
);

  logic [NUM_SUB-1:0] pend_q;
  logic [NUM_SUB-1:0] pend_d;

  assign pend_d = sub_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign agg_irq = |pend_q;

  p_pend_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_q == $past(sub_in));

  p_agg_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> agg_irq == (|$past(sub_in)));

endmodule

// File: rtl/kcs_mbox_ctrl.sv
module kcs_mbox_ctrl
  import kcs_mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int REG_W     = 32,
  parameter int DATA_W    = 8,
  parameter int NUM_WORDS = 72,
  parameter int NUM_SUB   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REG_W-1:0]          strap_cfg,
  input  logic                      lcl_en,
  input  logic                      lcl_we,
  input  logic [ADDR_W-1:0]         lcl_addr,
  input  logic [REG_W/8-1:0]        lcl_be,
  input  logic [REG_W-1:0]          lcl_wdata,
  output logic [REG_W-1:0]          lcl_rdata,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic                      host_stat,
  input  logic [$clog2(NUM_CH)-1:0] host_ch,
  input  logic [DATA_W-1:0]         host_wdata,
  output logic [DATA_W-1:0]         host_rdata,
  input  logic [NUM_SUB-1:0]        sub_irq_in,
  output logic [NUM_CH-1:0]         chan_irq,
  output logic                      agg_irq
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int CH_W   = $clog2(NUM_CH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WORD_W-1:0] lcl_word;
  logic              in_range, rd_req, wr_req;
  logic [1:0]        unused_addr_lsb;

  assign lcl_word        = lcl_addr[ADDR_W-1:2];
  assign unused_addr_lsb = lcl_addr[1:0];
  assign in_range        = int'(lcl_word) < NUM_WORDS;
  assign rd_req          = lcl_en && !lcl_we;
  assign wr_req          = lcl_en && lcl_we && in_range;

  logic              ctl_hit;
  logic [REG_W-1:0]  ctl_val;
  logic [NUM_CH-1:0] ch_en, ibf_ie;

  kcs_ctl_regs #(.REG_W(REG_W), .WORD_W(WORD_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strap_val (strap_cfg),
    .wr_en     (wr_req),
    .word      (lcl_word),
    .wr_be     (lcl_be),
    .wr_data   (lcl_wdata),
    .rd_hit    (ctl_hit),
    .rd_val    (ctl_val),
    .ch_en     (ch_en),
    .ibf_ie    (ibf_ie)
  );

  logic [NUM_CH-1:0][DATA_W-1:0] din_q, dout_q;
  logic [NUM_CH-1:0][ST_W-1:0]   st_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic l_din_rd, l_dout_wr, l_st_wr, h_din_wr, h_dout_rd, hsel;

    assign hsel      = (host_ch == CH_W'(c)) && !host_stat;
    assign l_din_rd  = rd_req && in_range && (int'(lcl_word) == din_word(c));
    assign l_dout_wr = wr_req && lcl_be[0] && (int'(lcl_word) == dout_word(c));
    assign l_st_wr   = wr_req && lcl_be[0] && (int'(lcl_word) == stat_word(c));
    assign h_din_wr  = host_wr && hsel;
    assign h_dout_rd = host_rd && hsel;

    kcs_chan #(.DATA_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .irq_arm    (ch_en[c] & ibf_ie[c]),
      .l_din_rd   (l_din_rd),
      .l_dout_wr  (l_dout_wr),
      .l_st_wr    (l_st_wr),
      .l_wdata    (lcl_wdata[DATA_W-1:0]),
      .l_st_wdata (lcl_wdata[ST_W-1:0]),
      .h_din_wr   (h_din_wr),
      .h_dout_rd  (h_dout_rd),
      .h_wdata    (host_wdata),
      .din_q      (din_q[c]),
      .dout_q     (dout_q[c]),
      .st_q       (st_q[c]),
      .irq_q      (chan_irq[c])
    );
  end

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (ctl_hit) rd_mux = ctl_val;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(lcl_word) == din_word(c))  rd_mux = REG_W'(din_q[c]);
      if (int'(lcl_word) == dout_word(c)) rd_mux = REG_W'(dout_q[c]);
      if (int'(lcl_word) == stat_word(c)) rd_mux = REG_W'(st_q[c]);
    end
    if (!in_range) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  lcl_rdata <= '0;
    else if (rd_req) lcl_rdata <= rd_mux;
  end

  logic [DATA_W-1:0] host_mux;
  assign host_mux = host_stat ? DATA_W'(st_q[host_ch]) : dout_q[host_ch];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   host_rdata <= '0;
    else if (host_rd) host_rdata <= host_mux;
  end

  kcs_irq_agg #(.NUM_SUB(NUM_SUB)) u_agg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sub_in  (sub_irq_in),
    .agg_irq (agg_irq)
  );

  p_oob_zero_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    lcl_en && !lcl_we && !in_range |=> lcl_rdata == '0);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_req |=> $stable(lcl_rdata));

  p_hrdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/tb_kcs_mbox_ctrl.sv
`timescale 1ns/1ps
module tb_kcs_mbox_ctrl;

  localparam logic [31:0] STRAP = 32'h5A3C_0F81;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lcl_en, lcl_we;
  logic [11:0] lcl_addr;
  logic [3:0]  lcl_be;
  logic [31:0] lcl_wdata, lcl_rdata;
  logic        host_wr, host_rd, host_stat;
  logic [1:0]  host_ch;
  logic [7:0]  host_wdata, host_rdata;
  logic        ext_irq;
  logic [4:0]  sub_irq_in;
  logic [3:0]  chan_irq;
  logic        agg_irq;

  always #2 clk = ~clk;  // 250 MHz

  assign sub_irq_in = {ext_irq, chan_irq};

  kcs_mbox_ctrl dut (
    .clk(clk), .rst_n(rst_n), .strap_cfg(STRAP),
    .lcl_en(lcl_en), .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_be(lcl_be),
    .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_stat(host_stat),
    .host_ch(host_ch), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sub_irq_in(sub_irq_in), .chan_irq(chan_irq), .agg_irq(agg_irq)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // reference model
  logic [31:0] m_ctl [10];
  logic [7:0]  m_din [4];
  logic [7:0]  m_dout[4];
  logic [7:0]  m_st  [4];
  logic [3:0]  m_irq;

  function automatic int w_ctl(int s);
    if (s < 5) return s;
    if (s < 9) return 32 + s - 5;
    return 64;
  endfunction
  function automatic int w_din(int c);  return c < 3 ? 9 + c  : 69; endfunction
  function automatic int w_dout(int c); return c < 3 ? 12 + c : 70; endfunction
  function automatic int w_stat(int c); return c < 3 ? 15 + c : 71; endfunction

  function automatic bit m_armed(int c);
    bit en, ie;
    case (c)
      0: begin en = m_ctl[0][5]; ie = m_ctl[2][1]; end
      1: begin en = m_ctl[0][6]; ie = m_ctl[2][2]; end
      2: begin en = m_ctl[0][7] & m_ctl[4][2]; ie = m_ctl[2][3]; end
      default: begin en = m_ctl[9][0]; ie = m_ctl[9][1]; end
    endcase
    return en & ie;
  endfunction

  function automatic logic [31:0] m_read(int w);
    if (w >= 72) return 32'h0;
    for (int s = 0; s < 10; s++) if (w == w_ctl(s)) return m_ctl[s];
    for (int c = 0; c < 4; c++) begin
      if (w == w_din(c))  return {24'h0, m_din[c]};
      if (w == w_dout(c)) return {24'h0, m_dout[c]};
      if (w == w_stat(c)) return {24'h0, m_st[c]};
    end
    return 32'h0;
  endfunction

  function automatic void m_write(int w, logic [3:0] be, logic [31:0] d);
    if (w >= 72) return;
    for (int s = 0; s < 10; s++)
      if (w == w_ctl(s))
        for (int l = 0; l < 4; l++) if (be[l]) m_ctl[s][l*8 +: 8] = d[l*8 +: 8];
    for (int c = 0; c < 4; c++) begin
      if (w == w_dout(c) && be[0]) begin m_dout[c] = d[7:0]; m_st[c][0] = 1'b1; end
      if (w == w_stat(c) && be[0]) m_st[c] = d[7:0];
    end
  endfunction

  function automatic void m_rd_effect(int w);
    for (int c = 0; c < 4; c++)
      if (w == w_din(c)) begin
        if (m_st[c][1]) m_irq[c] = 1'b0;
        m_st[c][1] = 1'b0;
      end
  endfunction

  function automatic void m_host_wr(int c, logic [7:0] d);
    m_din[c] = d;
    m_st[c][1] = 1'b1;
    if (m_armed(c)) m_irq[c] = 1'b1;
  endfunction

  function automatic int pick_word(int k);
    if (k < 10) return w_ctl(k);
    if (k < 14) return w_din(k - 10);
    if (k < 18) return w_dout(k - 14);
    if (k < 22) return w_stat(k - 18);
    if (k == 22) return 5;
    return 300;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one local access, one cycle; called at a falling edge
  task automatic lcl_op(bit we, int w, logic [3:0] be, logic [31:0] d, string req);
    logic [31:0] exp;
    logic        exp_agg;
    exp     = m_read(w);
    exp_agg = ext_irq | (|m_irq);
    lcl_en = 1'b1; lcl_we = we; lcl_addr = 12'(w * 4); lcl_be = be; lcl_wdata = d;
    @(negedge clk);
    lcl_en = 1'b0; lcl_we = 1'b0;
    if (we) m_write(w, be, d);
    else    m_rd_effect(w);
    if (!we) chk(req, lcl_rdata, exp);
    chk("R8 R9 irq", {28'h0, chan_irq}, {28'h0, m_irq});
    chk("R10 agg", {31'h0, agg_irq}, {31'h0, exp_agg});
  endtask

  task automatic host_op(bit wr, bit st, int c, logic [7:0] d, string req);
    logic [7:0] exp;
    logic       exp_agg;
    exp     = st ? m_st[c] : m_dout[c];
    exp_agg = ext_irq | (|m_irq);
    host_wr = wr; host_rd = !wr; host_stat = st; host_ch = 2'(c); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    if (wr && !st) m_host_wr(c, d);
    if (!wr && !st) m_st[c][0] = 1'b0;
    if (!wr) chk(req, {24'h0, host_rdata}, {24'h0, exp});
    chk("R8 R9 irq", {28'h0, chan_irq}, {28'h0, m_irq});
    chk("R10 agg", {31'h0, agg_irq}, {31'h0, exp_agg});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] old;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; lcl_en = 0; lcl_we = 0; lcl_addr = 0; lcl_be = 0; lcl_wdata = 0;
    host_wr = 0; host_rd = 0; host_stat = 0; host_ch = 0; host_wdata = 0; ext_irq = 0;
    for (int s = 0; s < 10; s++) m_ctl[s] = 32'h0;
    m_ctl[7] = STRAP;
    for (int c = 0; c < 4; c++) begin m_din[c] = 0; m_dout[c] = 0; m_st[c] = 0; end
    m_irq = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state, strap at 0x88
    for (int k = 0; k < 24; k++) lcl_op(0, pick_word(k), 4'h0, 32'h0, "R11 reset");
    chk("R11 strap", m_read(34), STRAP);

    // R7 R8 R3 R4: channel 1 armed
    lcl_op(1, 0, 4'hF, 32'h0000_0020, "R7");
    lcl_op(1, 2, 4'hF, 32'h0000_0002, "R8");
    host_op(1, 0, 0, 8'hA5, "R3");
    chk("R8 ch1 raised", {31'h0, chan_irq[0]}, 32'h1);
    host_op(0, 1, 0, 8'h00, "R3 status");
    lcl_op(0, 9, 4'h0, 0, "R4 din");
    lcl_op(0, 15, 4'h0, 0, "R4 ibf cleared");

    // R9: interrupt held when flag already clear
    host_op(1, 0, 0, 8'h11, "R3");
    lcl_op(1, 15, 4'h1, 32'h0000_0008, "R6 cd bit");
    lcl_op(0, 9, 4'h0, 0, "R9 din");
    chk("R9 irq held", {31'h0, chan_irq[0]}, 32'h1);
    host_op(1, 0, 0, 8'h22, "R3");
    lcl_op(0, 9, 4'h0, 0, "R9 drop");
    chk("R9 irq low", {31'h0, chan_irq[0]}, 32'h0);

    // R7 R8: channel 3 needs two enables
    lcl_op(1, 0, 4'h1, 32'h0000_00A0, "R7");
    lcl_op(1, 2, 4'h1, 32'h0000_000A, "R8");
    host_op(1, 0, 2, 8'h33, "R8 ch3 half");
    chk("R7 ch3 off", {31'h0, chan_irq[2]}, 32'h0);
    lcl_op(1, 4, 4'h1, 32'h0000_0004, "R7");
    host_op(1, 0, 2, 8'h34, "R8 ch3 full");
    chk("R7 ch3 on", {31'h0, chan_irq[2]}, 32'h1);

    // channel 4
    lcl_op(1, 64, 4'h1, 32'h0000_0003, "R7");
    host_op(1, 0, 3, 8'h44, "R8 ch4");
    chk("R8 ch4 raised", {31'h0, chan_irq[3]}, 32'h1);

    // R6: host status write ignored
    host_op(1, 1, 3, 8'hFF, "R6");
    host_op(0, 1, 3, 8'h00, "R6 status kept");

    // R5: output-full round trip
    lcl_op(1, 12, 4'h1, 32'h0000_003C, "R5");
    host_op(0, 1, 0, 0, "R5 obf set");
    host_op(0, 0, 0, 0, "R5 dout");
    host_op(0, 1, 0, 0, "R5 obf clear");

    // R4: same-cycle drain and fill on channel 1, host wins
    old = m_read(9);
    lcl_en = 1; lcl_we = 0; lcl_addr = 12'h024; lcl_be = 0;
    host_wr = 1; host_stat = 0; host_ch = 0; host_wdata = 8'h5E;
    @(negedge clk);
    lcl_en = 0; host_wr = 0;
    m_rd_effect(9); m_host_wr(0, 8'h5E);
    chk("R4 collide old", lcl_rdata, old);
    lcl_op(0, 15, 4'h0, 0, "R4 collide ibf");
    lcl_op(0, 9, 4'h0, 0, "R4 collide byte");

    // R2 R1: strobes, undefined and far words
    lcl_op(1, 32, 4'b0101, 32'hFFFF_FFFF, "R2");
    lcl_op(0, 32, 4'h0, 0, "R2 lanes");
    lcl_op(1, 13, 4'b1110, 32'hFFFF_FFFF, "R2 no lane0");
    lcl_op(0, 13, 4'h0, 0, "R2 dout kept");
    lcl_op(1, 5, 4'hF, 32'hDEAD_BEEF, "R1");
    lcl_op(0, 5, 4'h0, 0, "R1 undefined");
    lcl_op(1, 300, 4'hF, 32'hDEAD_BEEF, "R1");
    lcl_op(0, 300, 4'h0, 0, "R1 far");
    lcl_op(1, 10, 4'hF, 32'h0000_0077, "R1 din ro");
    lcl_op(0, 10, 4'h0, 0, "R1 din ro");

    // R10: free subdevice line
    lcl_op(0, 69, 4'h0, 0, "R9");
    lcl_op(0, 11, 4'h0, 0, "R9");
    lcl_op(0, 9, 4'h0, 0, "R9");
    ext_irq = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 ext high", {31'h0, agg_irq}, 32'h1);
    ext_irq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 all low", {31'h0, agg_irq}, {31'h0, |m_irq});

    // R12: read data holds without a read
    old = lcl_rdata;
    lcl_op(1, 1, 4'hF, 32'h1234_5678, "R12");
    chk("R12 hold", lcl_rdata, old);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r, w;
      r = int'($urandom % 8);
      w = pick_word(int'($urandom % 24));
      if (r < 4)
        lcl_op(bit'($urandom % 2), w, 4'($urandom), $urandom, "R1 R2 R4 R5 random");
      else
        host_op(bit'($urandom % 2), ($urandom % 4) == 0, int'($urandom % 4),
                8'($urandom), "R3 R5 R6 random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule